// File: doc/BRIEF.md
# Indirect Memory Access Window

This block sits on a narrow 16-bit host I/O bus and gives the host reach into a 32-bit internal address space through six small ports. The host loads an internal pointer in two 16-bit halves and then moves data through data ports. When the step control bit is set, the pointer advances after each data transfer, so long blocks can be streamed without reloading it.

The internal space is split by pointer bit 22. With the bit clear, the pointer names a 16-bit data word. With the bit set, the pointer names a 32-bit program word: program word `w` sits at internal address `(w << 2) | (1 << 22)`. A program word moves as two halves, the low half through its own port and then the high half through the shared data port. A further port fetches a data word and zeroes that location in the same host access. Every internal transfer is a request/acknowledge handshake, and the host bus is held off with a ready signal until the transfer completes.

The host protocol works as follows. The host raises `host_cs` together with `host_we`, `host_ofs` and `host_wdata`. It holds them until it sees `host_ready` high for one cycle, and it lowers `host_cs` before the next rising edge.

Top module: `imw_window`

## Requirements
- R1: After a synchronous reset, reads of the pointer halves (offsets 0x4 and 0x6) and of the control port (offset 0x2) return 0, which means stepping is off.
- R2: A write to offset 0x4 loads pointer bits 15:0 and a write to offset 0x6 loads bits 31:16, and neither write disturbs the other half. Both halves read back at the same offsets.
- R3: With pointer bit 22 clear, a write to offset 0x8 issues one internal write at the pointer, with data `{16'h0, wdata}`. A read of offset 0x8 returns internal bits 15:0 from the pointer.
- R4: With pointer bit 22 set, internal transfers go to the pointer unchanged. Program word `w` therefore sits at `(w << 2) | 0x400000`.
- R5: A write to offset 0xA only stores the low half inside the block and makes no internal access. The next write to offset 0x8 with bit 22 set issues one internal write of `{high, low}`.
- R6: With bit 22 set, a read of offset 0xA returns internal bits 15:0, and a read of offset 0x8 returns internal bits 31:16.
- R7: A read of offset 0xC returns internal bits 15:0 and then writes zero to the same internal address before ready is given.
- R8: Control bit 1 at offset 0x2 enables stepping. With it set, every data-word access through offset 0x8 or 0xC adds 1 to the pointer.
- R9: With stepping on in the program region, an access through offset 0xA leaves the pointer unchanged and an access through offset 0x8 adds 4.
- R10: With stepping off, data accesses leave the pointer unchanged.
- R11: An internal request stays high with a stable address until it is acknowledged. A register-only access gives ready one cycle after it is accepted. A single internal transfer acknowledged `d` cycles after the request gives ready `d+2` cycles after the host raises `host_cs`.
- R12: Writes to offset 0xC and accesses to unmapped offsets make no internal access, and such reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 4 | Port offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid with ready |
| host_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Internal transfer request |
| mem_we | output | 1 | Internal write enable |
| mem_addr | output | 32 | Internal address (the pointer) |
| mem_wdata | output | 32 | Internal write data |
| mem_rdata | input | 32 | Internal read data, valid with ack |
| mem_ack | input | 1 | Internal transfer acknowledge |

## Verification
A register-only access yields ready in the first sampled cycle after the strobe. A single internal transfer acknowledged `d` cycles late yields ready in sampled cycle `d+2`, and a read-and-clear spans two transfers. The bench drives the strobe on a falling edge and counts falling edges until ready, then compares that count with these figures. Data, the pointer and the internal side effects are checked only after ready is seen: the pointer through its readback ports, and the internal side effects through the access log and the contents of the bench memory model.

// File: rtl/imw_pkg.sv
package imw_pkg;
  localparam int OFS_W = 4;
  localparam logic [OFS_W-1:0] OFS_CTRL = 4'h2;
  localparam logic [OFS_W-1:0] OFS_PLO  = 4'h4;
  localparam logic [OFS_W-1:0] OFS_PHI  = 4'h6;
  localparam logic [OFS_W-1:0] OFS_DATA = 4'h8;
  localparam logic [OFS_W-1:0] OFS_PGLO = 4'hA;
  localparam logic [OFS_W-1:0] OFS_RCLR = 4'hC;

  typedef enum logic [2:0] {
    OP_NONE, OP_CTRL, OP_PLO, OP_PHI, OP_DW, OP_PG_LO, OP_PG_HI, OP_RCLR
  } op_e;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_CLR, S_RESP} st_e;
endpackage

// File: rtl/imw_decode.sv
module imw_decode
  import imw_pkg::*;
(
  input  logic [OFS_W-1:0] ofs,
  input  logic             we,
  input  logic             pg_region,
  output op_e              op,
  output logic             use_mem
);
  always_comb begin
    case (ofs)
      OFS_CTRL: op = OP_CTRL;
      OFS_PLO:  op = OP_PLO;
      OFS_PHI:  op = OP_PHI;
      OFS_DATA: op = pg_region ? OP_PG_HI : OP_DW;
      OFS_PGLO: op = OP_PG_LO;
      OFS_RCLR: op = OP_RCLR;
      default:  op = OP_NONE;
    endcase
    use_mem = (op == OP_DW) || (op == OP_PG_HI) ||
              ((op == OP_PG_LO) && !we) || ((op == OP_RCLR) && !we);
  end
endmodule

// File: rtl/imw_ptr.sv
module imw_ptr #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [HW-1:0] din,
  input  logic          step,
  input  logic          step_wide,
  output logic [2*HW-1:0] ptr
);
  localparam int AW = 2 * HW;
  localparam logic [AW-1:0] STEP_NARROW = AW'(1);
  localparam logic [AW-1:0] STEP_WIDE   = AW'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else begin
      if (ld_lo) ptr[HW-1:0]  <= din;
      if (ld_hi) ptr[AW-1:HW] <= din;
      if (step)  ptr <= ptr + (step_wide ? STEP_WIDE : STEP_NARROW);
    end
  end

  // R2: loading one half leaves the other half alone
  p_lo_keeps_hi_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_lo && !ld_hi && !step) |=> $stable(ptr[AW-1:HW]));
  p_hi_keeps_lo_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_hi && !ld_lo && !step) |=> $stable(ptr[HW-1:0]));
endmodule

// File: rtl/imw_seq.sv
module imw_seq
  import imw_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_cs,
  input  logic            host_we,
  input  logic [HW-1:0]   host_wdata,
  input  op_e             op,
  input  logic            use_mem,
  input  logic [2*HW-1:0] ptr,
  output logic [HW-1:0]   host_rdata,
  output logic            host_ready,
  output logic            ld_lo,
  output logic            ld_hi,
  output logic            step,
  output logic            step_wide,
  output logic            mem_req,
  output logic            mem_we,
  output logic [2*HW-1:0] mem_wdata,
  input  logic [2*HW-1:0] mem_rdata,
  input  logic            mem_ack
);
  localparam int MW = 2 * HW;

  st_e           st;
  op_e           op_q;
  logic          step_en;
  logic [HW-1:0] lo_buf;
  logic          accept;
  logic          done;

  assign accept = host_cs && (st == S_IDLE);
  assign done   = mem_ack && (((st == S_XFER) && (op_q != OP_RCLR)) || (st == S_CLR));

  assign ld_lo     = accept && host_we && (op == OP_PLO);
  assign ld_hi     = accept && host_we && (op == OP_PHI);
  assign step      = done && step_en && (op_q != OP_PG_LO);
  assign step_wide = (op_q == OP_PG_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      op_q       <= OP_NONE;
      step_en    <= 1'b0;
      lo_buf     <= '0;
      host_rdata <= '0;
      host_ready <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_wdata  <= '0;
    end else begin
      case (st)
        S_IDLE: if (host_cs) begin
          op_q <= op;
          if (use_mem) begin
            st      <= S_XFER;
            mem_req <= 1'b1;
            mem_we  <= host_we;
            mem_wdata <= (op == OP_PG_HI) ? {host_wdata, lo_buf}
                                          : {{(MW-HW){1'b0}}, host_wdata};
          end else begin
            st         <= S_RESP;
            host_ready <= 1'b1;
            host_rdata <= '0;
            if (!host_we) begin
              case (op)
                OP_CTRL: host_rdata <= HW'({step_en, 1'b0});
                OP_PLO:  host_rdata <= ptr[HW-1:0];
                OP_PHI:  host_rdata <= ptr[MW-1:HW];
                default: host_rdata <= '0;
              endcase
            end else begin
              if (op == OP_CTRL)  step_en <= host_wdata[1];
              if (op == OP_PG_LO) lo_buf  <= host_wdata;
            end
          end
        end
        S_XFER: if (mem_ack) begin
          host_rdata <= (op_q == OP_PG_HI) ? mem_rdata[MW-1:HW] : mem_rdata[HW-1:0];
          if (op_q == OP_RCLR) begin
            st        <= S_CLR;
            mem_we    <= 1'b1;
            mem_wdata <= '0;
          end else begin
            st         <= S_RESP;
            mem_req    <= 1'b0;
            mem_we     <= 1'b0;
            host_ready <= 1'b1;
          end
        end
        S_CLR: if (mem_ack) begin
          st         <= S_RESP;
          mem_req    <= 1'b0;
          mem_we     <= 1'b0;
          host_ready <= 1'b1;
        end
        default: begin
          st         <= S_IDLE;
          host_ready <= 1'b0;
        end
      endcase
    end
  end

  // R11: request held with stable address until acknowledged
  p_req_held_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(ptr) && $stable(mem_we)));
  // R11: ready is a single-cycle pulse and never overlaps a transfer
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> !mem_req);
  // R7: read phase of read-and-clear is followed by a zero write, same address
  p_rclr_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ((st == S_XFER) && (op_q == OP_RCLR) && mem_ack) |=>
      (mem_req && mem_we && (mem_wdata == '0) && $stable(ptr)));
  // R5: low-half write only buffers
  p_pglo_local_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && host_we && (op == OP_PG_LO)) |=> !mem_req);
  // R12: unmapped offsets never reach the internal side
  p_none_local_r12: assert property (@(posedge clk) disable iff (rst)
    (accept && (op == OP_NONE)) |=> !mem_req);
endmodule

// File: rtl/imw_window.sv
module imw_window
  import imw_pkg::*;
#(
  parameter int HW     = 16,
  parameter int PG_BIT = 22
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_cs,
  input  logic            host_we,
  input  logic [3:0]      host_ofs,
  input  logic [HW-1:0]   host_wdata,
  output logic [HW-1:0]   host_rdata,
  output logic            host_ready,
  output logic            mem_req,
  output logic            mem_we,
  output logic [2*HW-1:0] mem_addr,
  output logic [2*HW-1:0] mem_wdata,
  input  logic [2*HW-1:0] mem_rdata,
  input  logic            mem_ack
);
  op_e             op;
  logic            use_mem;
  logic            ld_lo, ld_hi, step, step_wide;
  logic [2*HW-1:0] ptr;

  imw_decode u_dec (
    .ofs(host_ofs), .we(host_we), .pg_region(ptr[PG_BIT]),
    .op(op), .use_mem(use_mem)
  );

  imw_ptr #(.HW(HW)) u_ptr (
    .clk(clk), .rst(rst), .ld_lo(ld_lo), .ld_hi(ld_hi), .din(host_wdata),
    .step(step), .step_wide(step_wide), .ptr(ptr)
  );

  imw_seq #(.HW(HW)) u_seq (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
    .host_wdata(host_wdata), .op(op), .use_mem(use_mem), .ptr(ptr),
    .host_rdata(host_rdata), .host_ready(host_ready),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .step(step), .step_wide(step_wide),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  assign mem_addr = ptr;
endmodule

// File: tb/imw_window_tb_top.sv
`timescale 1ns/1ps
module imw_window_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_cs = 1'b0, host_we = 1'b0;
  logic [3:0]  host_ofs = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0, fails = 0;
  int dly = 0, cnt = 0;
  int n_acc = 0;
  logic [31:0] last_addr, last_wdata;
  logic        last_we;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] ref_mem [logic [31:0]];
  logic [31:0] e_ptr = '0;
  logic        e_step = 1'b0;

  always #2.5 clk = ~clk;

  imw_window dut_i (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we), .host_ofs(host_ofs),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // internal memory model, acts on falling edges
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0; cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; cnt = 0;
    end else if (mem_req) begin
      if (cnt >= dly) begin
        mem_ack = 1'b1;
        n_acc++; last_addr = mem_addr; last_we = mem_we; last_wdata = mem_wdata;
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      end else cnt++;
    end
  end

  function automatic logic [31:0] pg_addr(input int w);
    return (32'(w) << 2) | 32'h0040_0000;
  endfunction

  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [3:0] ofs, input logic [15:0] wd,
                     output logic [15:0] rd, output int lat);
    @(negedge clk);
    host_cs = 1'b1; host_we = we; host_ofs = ofs; host_wdata = wd;
    lat = 0; rd = '0;
    forever begin
      @(negedge clk);
      lat++;
      if (host_ready) begin rd = host_rdata; break; end
      if (lat > 60) begin
        chk(1'b0, "R11 timeout", 32'(lat), 32'd60);
        break;
      end
    end
    host_cs = 1'b0;
  endtask

  task automatic set_ptr(input logic [31:0] a);
    logic [15:0] r; int l;
    acc(1'b1, 4'h4, a[15:0], r, l);
    acc(1'b1, 4'h6, a[31:16], r, l);
    e_ptr = a;
  endtask

  task automatic chk_ptr(input string req);
    logic [15:0] lo, hi; int l;
    acc(1'b0, 4'h4, 16'h0, lo, l);
    acc(1'b0, 4'h6, 16'h0, hi, l);
    chk({hi, lo} == e_ptr, req, {hi, lo}, e_ptr);
  endtask

  task automatic set_step(input bit en);
    logic [15:0] r; int l;
    acc(1'b1, 4'h2, {14'h0, en, 1'b0}, r, l);
    e_step = en;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r; int l, n0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    acc(1'b0, 4'h2, 16'h0, r, l); chk(r == 16'h0, "R1 ctrl", r, 0);
    chk(l == 1, "R11 reg latency", l, 1);
    chk_ptr("R1 pointer");

    // R2 halves independent
    acc(1'b1, 4'h4, 16'h1234, r, l);
    e_ptr = 32'h0000_1234; chk_ptr("R2 low half");
    acc(1'b1, 4'h6, 16'h00AB, r, l);
    e_ptr = 32'h00AB_1234; chk_ptr("R2 high half");

    // R3 data word write and read, R10 no stepping, R11 latency
    set_ptr(32'h10); dly = 0;
    n0 = n_acc;
    acc(1'b1, 4'h8, 16'hBEEF, r, l);
    chk(n_acc == n0 + 1 && last_we && last_addr == 32'h10, "R3 write addr", last_addr, 32'h10);
    chk(last_wdata == 32'h0000_BEEF, "R3 write data", last_wdata, 32'h0000_BEEF);
    chk(l == 2, "R11 latency d0", l, 2);
    ref_mem[32'h10] = 32'h0000_BEEF;
    dly = 3;
    acc(1'b0, 4'h8, 16'h0, r, l);
    chk(r == 16'hBEEF, "R3 read", r, 16'hBEEF);
    chk(l == 5, "R11 latency d3", l, 5);
    chk_ptr("R10 no step");
    dly = 0;

    // R8 stepping on data words
    set_step(1'b1);
    acc(1'b0, 4'h2, 16'h0, r, l); chk(r == 16'h0002, "R8 ctrl readback", r, 2);
    set_ptr(32'h20);
    for (int i = 0; i < 3; i++) begin
      acc(1'b1, 4'h8, 16'(16'h100 + i), r, l);
      ref_mem[32'h20 + i] = 32'(16'h100 + i);
    end
    e_ptr = 32'h23; chk_ptr("R8 step by one");
    chk(mem[32'h22] == 32'h102, "R8 stepped write", mem[32'h22], 32'h102);

    // R4 R5 R9 program word write
    set_ptr(pg_addr(5));
    n0 = n_acc;
    acc(1'b1, 4'hA, 16'h1111, r, l);
    chk(n_acc == n0, "R5 low buffered", n_acc, n0);
    chk_ptr("R9 low no step");
    acc(1'b1, 4'h8, 16'h2222, r, l);
    chk(last_addr == pg_addr(5), "R4 program address", last_addr, pg_addr(5));
    chk(last_we && last_wdata == 32'h2222_1111, "R5 joined word", last_wdata, 32'h2222_1111);
    ref_mem[pg_addr(5)] = 32'h2222_1111;
    e_ptr = pg_addr(6); chk_ptr("R9 step by four");
    // R6 program word read
    set_ptr(pg_addr(5));
    acc(1'b0, 4'hA, 16'h0, r, l); chk(r == 16'h1111, "R6 low read", r, 16'h1111);
    chk_ptr("R9 low read no step");
    acc(1'b0, 4'h8, 16'h0, r, l); chk(r == 16'h2222, "R6 high read", r, 16'h2222);
    e_ptr = pg_addr(6); chk_ptr("R9 high read step");

    // R7 read and clear
    set_ptr(32'h30); dly = 1;
    acc(1'b1, 4'h8, 16'hCAFE, r, l);
    set_ptr(32'h30);
    acc(1'b0, 4'hC, 16'h0, r, l);
    chk(r == 16'hCAFE, "R7 returned", r, 16'hCAFE);
    chk(mem[32'h30] == 32'h0, "R7 cleared", mem[32'h30], 0);
    e_ptr = 32'h31; chk_ptr("R8 step after clear");
    set_ptr(32'h30);
    acc(1'b0, 4'h8, 16'h0, r, l); chk(r == 16'h0, "R7 reads zero", r, 0);
    ref_mem[32'h30] = 32'h0;

    // R12 ignored writes and unmapped reads
    set_ptr(32'h10);
    n0 = n_acc;
    acc(1'b1, 4'hC, 16'h5555, r, l);
    acc(1'b1, 4'hE, 16'h5555, r, l);
    acc(1'b0, 4'hE, 16'h0, r, l);
    chk(n_acc == n0 && r == 16'h0, "R12 no access", n_acc - n0, 0);
    chk(mem[32'h10] == 32'h0000_BEEF, "R12 memory intact", mem[32'h10], 32'h0000_BEEF);
    chk_ptr("R12 pointer intact");

    // random mix against the bench reference
    for (int k = 0; k < 300; k++) begin
      int kind; logic [31:0] a; logic [15:0] d0, d1;
      kind = $urandom_range(0, 4);
      dly = $urandom_range(0, 3);
      d0 = 16'($urandom); d1 = 16'($urandom);
      if ($urandom_range(0, 3) == 0) set_step(1'($urandom_range(0, 1)));
      if (kind >= 3) a = pg_addr($urandom_range(0, 15));
      else a = 32'($urandom_range(0, 63));
      set_ptr(a);
      case (kind)
        0: begin
          acc(1'b1, 4'h8, d0, r, l);
          ref_mem[a] = {16'h0, d0};
          if (e_step) e_ptr = a + 1;
        end
        1: begin
          acc(1'b0, 4'h8, 16'h0, r, l);
          chk(r == ref_rd(a)[15:0], "R3 random read", r, ref_rd(a)[15:0]);
          if (e_step) e_ptr = a + 1;
        end
        2: begin
          acc(1'b0, 4'hC, 16'h0, r, l);
          chk(r == ref_rd(a)[15:0], "R7 random clear read", r, ref_rd(a)[15:0]);
          ref_mem[a] = 32'h0;
          if (e_step) e_ptr = a + 1;
        end
        3: begin
          acc(1'b1, 4'hA, d0, r, l);
          acc(1'b1, 4'h8, d1, r, l);
          ref_mem[a] = {d1, d0};
          if (e_step) e_ptr = a + 4;
        end
        default: begin
          acc(1'b0, 4'hA, 16'h0, r, l);
          chk(r == ref_rd(a)[15:0], "R6 random low", r, ref_rd(a)[15:0]);
          acc(1'b0, 4'h8, 16'h0, r, l);
          chk(r == ref_rd(a)[31:16], "R6 random high", r, ref_rd(a)[31:16]);
          if (e_step) e_ptr = a + 4;
        end
      endcase
      if (k % 10 == 0) chk_ptr("R8 R9 R10 random pointer");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule